// File: doc/BRIEF.md
# Destination Address Filter Decision

This block sits beside a receive path and decides, once per frame, what happens to that frame based on its 48-bit destination address. When the upstream parser presents the address with a one-cycle valid strobe, together with the ID of the port the frame arrived on, the block classifies the frame as broadcast, multicast or unicast. For unicast frames it issues a request to an external address table and waits for an acknowledge carrying a hit flag and the stored port ID.

On a hit where the stored port equals the arrival port, the frame would go back out where it came from. The block therefore raises a reject flag and forces the receive-error line toward the MAC high, so the MAC drops the frame. On a hit to a different port, it announces the destination port on a serial tag port, most significant bit first. Outside of a rejection, the receive-error line passes straight through. A frame ends when carrier sense is sampled low, which clears all per-frame state.

Top module: `dest_filter`

## Requirements
- R1: An address with all 48 bits set is reported as broadcast, code 2'b11 on `frm_class`, starting the cycle after `da_valid` is sampled.
- R2: An address that is not broadcast and whose group bit is set is reported as multicast, code 2'b10. The group bit is `da[40]`, the least significant bit of the first octet, held in `da[47:40]`.
- R3: Any other address is reported as unicast, code 2'b01. `frm_class` reads 2'b00 when no frame is active and returns to 2'b00 the cycle after `crs` is sampled low.
- R4: Only a unicast frame raises `lk_req`, in the same cycle its class appears, with `lk_addr` equal to the sampled address. Broadcast and multicast frames never raise it.
- R5: `lk_req` and `lk_addr` hold steady until `lk_ack` is sampled high. `lk_req` is low in the following cycle.
- R6: When the acknowledge reports a hit and `lk_port` equals the arrival port, `reject` rises the cycle after the acknowledge and `rxer_out` is high.
- R7: `reject` and the forcing of `rxer_out` stay asserted while `crs` is high, and both clear the cycle after `crs` is sampled low.
- R8: While `reject` is low, `rxer_out` equals `rxer_in` in the same cycle.
- R9: When the acknowledge reports a hit to a different port, `tag_valid` is high for exactly PORT_W cycles starting the cycle after the acknowledge. During those cycles `tag_data` carries `lk_port` from its most significant bit down.
- R10: A lookup miss causes neither a rejection nor any tag output.
- R11: A `da_valid` strobe that arrives while a frame is active is ignored. The class, the request and the requested address are unchanged.
- R12: If `crs` is sampled low while a lookup is outstanding, `lk_req` drops in the next cycle, and any later acknowledge causes neither a rejection nor a tag output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crs | input | 1 | Carrier sense; a low sample ends the frame |
| da_valid | input | 1 | One-cycle strobe: `da` and `src_port` are valid |
| da | input | 48 | Destination address; first octet in bits 47:40 |
| src_port | input | 4 | ID of the port the frame arrived on |
| rxer_in | input | 1 | Receive-error line from the PHY side |
| lk_ack | input | 1 | Table acknowledge; `lk_hit` and `lk_port` are valid |
| lk_hit | input | 1 | Table hit flag |
| lk_port | input | 4 | Port ID stored in the table for the address |
| lk_req | output | 1 | Table lookup request |
| lk_addr | output | 48 | Address to look up |
| frm_class | output | 2 | Frame class: 00 none, 01 unicast, 10 multicast, 11 broadcast |
| reject | output | 1 | Frame rejected because the destination equals the arrival port |
| rxer_out | output | 1 | Receive-error line to the MAC, forced high on rejection |
| tag_valid | output | 1 | Serial tag output is active |
| tag_data | output | 1 | Serial destination port ID, MSB first |

## Verification
A wrong frame-state flag shows one cycle after the strobe, either as a wrong or missing class code or as a request raised for a group address. A corrupted lookup state shows as a request that drops before its acknowledge, or that survives the end of the frame. An error in the port comparison or the serializer appears one cycle after the acknowledge: `reject` and `tag_valid` swap, or one of the PORT_W tag bits comes out wrong. A reject flag that does not clear is visible on `rxer_out` one cycle after carrier sense falls.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;
    typedef enum logic [1:0] {
        CLS_NONE  = 2'b00,
        CLS_UCAST = 2'b01,
        CLS_MCAST = 2'b10,
        CLS_BCAST = 2'b11
    } frm_class_e;

    typedef enum logic [0:0] {
        LK_IDLE = 1'b0,
        LK_WAIT = 1'b1
    } lk_state_e;
endpackage

// File: rtl/dfilt_classify.sv
module dfilt_classify
    import dfilt_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] addr,
    output frm_class_e        cls
);
    // the group bit is the lowest bit of the first-transmitted octet
    localparam int GRP_BIT = ADDR_W - 8;

    always_comb begin
        if (&addr)
            cls = CLS_BCAST;
        else if (addr[GRP_BIT])
            cls = CLS_MCAST;
        else
            cls = CLS_UCAST;
    end
endmodule

// File: rtl/dfilt_lookup.sv
module dfilt_lookup
    import dfilt_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] src_port,
    input  logic              crs,
    input  logic              lk_ack,
    input  logic              lk_hit,
    input  logic [PORT_W-1:0] lk_port,
    output logic              lk_req,
    output logic [ADDR_W-1:0] lk_addr,
    output logic              rej_set,
    output logic              tag_load
);
    typedef struct packed {
        lk_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [PORT_W-1:0] src;
    } lk_regs_t;

    lk_regs_t r_d, r_q;
    logic     resp;
    logic     same_port;

    assign resp      = (r_q.st == LK_WAIT) && lk_ack && crs;
    assign same_port = (lk_port == r_q.src);
    assign rej_set   = resp && lk_hit && same_port;
    assign tag_load  = resp && lk_hit && !same_port;
    assign lk_req    = (r_q.st == LK_WAIT);
    assign lk_addr   = r_q.addr;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            LK_IDLE: begin
                if (start) begin
                    r_d.st   = LK_WAIT;
                    r_d.addr = addr;
                    r_d.src  = src_port;
                end
            end
            LK_WAIT: begin
                if (!crs || lk_ack)
                    r_d.st = LK_IDLE;
            end
            default: r_d.st = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '{st: LK_IDLE, addr: '0, src: '0};
        else
            r_q <= r_d;
    end

    // R5: request and address held until acknowledged
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && !lk_ack && crs |=> lk_req && $stable(lk_addr));
    // R5: request released after the acknowledge
    a_r5_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && lk_ack |=> !lk_req);
    // R12: end of frame aborts the lookup
    a_r12_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !crs |=> !lk_req);
endmodule

// File: rtl/dfilt_tag_ser.sv
module dfilt_tag_ser #(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PORT_W-1:0] word,
    output logic              tag_valid,
    output logic              tag_data
);
    localparam int CNT_W = $clog2(PORT_W + 1);

    typedef struct packed {
        logic [PORT_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } ser_regs_t;

    ser_regs_t s_d, s_q;

    assign tag_valid = (s_q.cnt != '0);
    assign tag_data  = tag_valid && s_q.sh[PORT_W-1];

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.sh  = word;
            s_d.cnt = CNT_W'(PORT_W);
        end else if (s_q.cnt != '0) begin
            s_d.sh  = s_q.sh << 1;
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    // R9: a load starts the tag with the port's top bit
    a_r9_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> tag_valid && (tag_data == $past(word[PORT_W-1])));
endmodule

// File: rtl/dest_filter.sv
module dest_filter
    import dfilt_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crs,
    input  logic              da_valid,
    input  logic [ADDR_W-1:0] da,
    input  logic [PORT_W-1:0] src_port,
    input  logic              rxer_in,
    input  logic              lk_ack,
    input  logic              lk_hit,
    input  logic [PORT_W-1:0] lk_port,
    output logic              lk_req,
    output logic [ADDR_W-1:0] lk_addr,
    output logic [1:0]        frm_class,
    output logic              reject,
    output logic              rxer_out,
    output logic              tag_valid,
    output logic              tag_data
);
    typedef struct packed {
        logic       active;
        frm_class_e cls;
        logic       rej;
    } frm_regs_t;

    frm_regs_t  f_d, f_q;
    frm_class_e cls_now;
    logic       accept;
    logic       start;
    logic       rej_set;
    logic       tag_load;

    dfilt_classify #(.ADDR_W(ADDR_W)) u_cls (
        .addr (da),
        .cls  (cls_now)
    );

    assign accept = da_valid && crs && !f_q.active;
    assign start  = accept && (cls_now == CLS_UCAST);

    dfilt_lookup #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_lk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .addr     (da),
        .src_port (src_port),
        .crs      (crs),
        .lk_ack   (lk_ack),
        .lk_hit   (lk_hit),
        .lk_port  (lk_port),
        .lk_req   (lk_req),
        .lk_addr  (lk_addr),
        .rej_set  (rej_set),
        .tag_load (tag_load)
    );

    dfilt_tag_ser #(.PORT_W(PORT_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tag_load),
        .word      (lk_port),
        .tag_valid (tag_valid),
        .tag_data  (tag_data)
    );

    always_comb begin
        f_d = f_q;
        if (!crs) begin
            f_d.active = 1'b0;
            f_d.cls    = CLS_NONE;
            f_d.rej    = 1'b0;
        end else begin
            if (accept) begin
                f_d.active = 1'b1;
                f_d.cls    = cls_now;
            end
            if (rej_set)
                f_d.rej = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            f_q <= '{active: 1'b0, cls: CLS_NONE, rej: 1'b0};
        else
            f_q <= f_d;
    end

    assign frm_class = f_q.cls;
    assign reject    = f_q.rej;
    assign rxer_out  = rxer_in || f_q.rej;

    // R4: a lookup only ever starts for a unicast frame
    a_r4_req_ucast: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lk_req) |-> frm_class == CLS_UCAST);
    // R6: the error line is forced while rejecting
    a_r6_rxer_forced: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> rxer_out);
    // R7: end of frame clears rejection and class
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !crs |=> !reject && frm_class == CLS_NONE);
    // R9: rejection and a fresh tag never start together
    a_r9_tag_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reject) |-> !$rose(tag_valid));
endmodule

// File: tb/dest_filter_bench.sv
`timescale 1ns/1ps
module dest_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crs = 1'b0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic [3:0]  src_port = '0;
    logic        rxer_in = 1'b0;
    logic        lk_ack = 1'b0;
    logic        lk_hit = 1'b0;
    logic [3:0]  lk_port = '0;
    logic        lk_req;
    logic [47:0] lk_addr;
    logic [1:0]  frm_class;
    logic        reject;
    logic        rxer_out;
    logic        tag_valid;
    logic        tag_data;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    dest_filter u_dest_filter (
        .clk(clk), .rst_n(rst_n), .crs(crs), .da_valid(da_valid), .da(da),
        .src_port(src_port), .rxer_in(rxer_in), .lk_ack(lk_ack), .lk_hit(lk_hit),
        .lk_port(lk_port), .lk_req(lk_req), .lk_addr(lk_addr), .frm_class(frm_class),
        .reject(reject), .rxer_out(rxer_out), .tag_valid(tag_valid), .tag_data(tag_data)
    );

    function automatic logic [1:0] exp_class(input logic [47:0] a);
        if (&a) return 2'b11;
        if (a[40]) return 2'b10;
        return 2'b01;
    endfunction

    function automatic string cls_req(input logic [1:0] c);
        if (c == 2'b11) return "R1";
        if (c == 2'b10) return "R2";
        return "R3";
    endfunction

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
        end
    endtask

    task automatic do_frame(input logic [47:0] a, input logic [3:0] sp,
                            input bit hit, input logic [3:0] pp, input int dly);
        logic [1:0] ec;
        bit uc, erej, etag;
        ec   = exp_class(a);
        uc   = (ec == 2'b01);
        erej = uc && hit && (pp == sp);
        etag = uc && hit && (pp != sp);
        @(negedge clk);
        crs = 1'b1; da_valid = 1'b1; da = a; src_port = sp;
        @(negedge clk);
        da_valid = 1'b0;
        chk(cls_req(ec), frm_class, ec);
        chk("R4", lk_req, uc);
        if (uc) begin
            chk("R4", lk_addr, a);
            for (int k = 0; k < dly; k++) begin
                @(negedge clk);
                chk("R5", lk_req, 1);
            end
            lk_ack = 1'b1; lk_hit = hit; lk_port = pp;
            @(negedge clk);
            lk_ack = 1'b0;
            chk("R5", lk_req, 0);
            chk(erej ? "R6" : "R10", reject, erej);
            chk(etag ? "R9" : "R10", tag_valid, etag);
            if (etag) begin
                for (int i = 3; i >= 0; i--) begin
                    chk("R9", {tag_valid, tag_data}, {1'b1, pp[i]});
                    @(negedge clk);
                end
                chk("R9", tag_valid, 0);
            end
        end
        rxer_in = 1'b0; #1;
        chk(erej ? "R6" : "R8", rxer_out, erej);
        rxer_in = 1'b1; #1;
        chk("R8", rxer_out, 1);
        rxer_in = 1'b0;
        if (erej) begin
            @(negedge clk);
            chk("R7", reject, 1);
        end
        crs = 1'b0;
        @(negedge clk);
        chk("R7", reject, 0);
        chk("R3", frm_class, 2'b00);
        #1;
        chk("R7", rxer_out, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R3", frm_class, 2'b00);
        chk("R4", lk_req, 0);
        chk("R6", reject, 0);
        chk("R9", tag_valid, 0);
        rst_n = 1'b1;

        // directed corners
        do_frame(48'hFFFF_FFFF_FFFF, 4'h2, 1'b1, 4'h2, 0);        // R1
        do_frame(48'h0100_5E00_0001, 4'h2, 1'b1, 4'h2, 0);        // R2
        do_frame(48'hFFFF_FFFF_FFFE, 4'h3, 1'b0, 4'h0, 0);        // R2 near broadcast
        do_frame(48'h0200_0000_0005, 4'h5, 1'b1, 4'h5, 0);        // R6
        do_frame(48'h0200_0000_0006, 4'h5, 1'b1, 4'hA, 3);        // R9
        do_frame(48'hFEFF_FFFF_FFFF, 4'h0, 1'b1, 4'hF, 1);        // R9, R3
        do_frame(48'h0000_0000_0000, 4'hF, 1'b1, 4'h0, 2);        // R9
        do_frame(48'h0200_0000_0007, 4'h1, 1'b0, 4'h1, 2);        // R10

        // R11: second strobe during an active frame is ignored
        @(negedge clk);
        crs = 1'b1; da_valid = 1'b1; da = 48'h0200_0000_00AA; src_port = 4'h4;
        @(negedge clk);
        da = 48'hFFFF_FFFF_FFFF; src_port = 4'h9;
        @(negedge clk);
        da_valid = 1'b0;
        chk("R11", frm_class, 2'b01);
        chk("R11", lk_req, 1);
        chk("R11", lk_addr, 48'h0200_0000_00AA);
        lk_ack = 1'b1; lk_hit = 1'b1; lk_port = 4'h4;
        @(negedge clk);
        lk_ack = 1'b0;
        chk("R11", reject, 1);
        crs = 1'b0;
        @(negedge clk);
        chk("R7", reject, 0);

        // R12: frame ends before the acknowledge
        @(negedge clk);
        crs = 1'b1; da_valid = 1'b1; da = 48'h0400_0000_0001; src_port = 4'h6;
        @(negedge clk);
        da_valid = 1'b0;
        chk("R12", lk_req, 1);
        crs = 1'b0;
        @(negedge clk);
        chk("R12", lk_req, 0);
        lk_ack = 1'b1; lk_hit = 1'b1; lk_port = 4'h6;
        @(negedge clk);
        lk_ack = 1'b0;
        chk("R12", reject, 0);
        chk("R12", tag_valid, 0);
        #1;
        chk("R12", rxer_out, 0);

        // constrained random frames
        for (int n = 0; n < 80; n++) begin
            logic [47:0] a;
            logic [3:0]  sp, pp;
            int          kind;
            kind = $urandom % 4;
            a    = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            if (kind == 0)      a = '1;
            else if (kind == 1) a[40] = 1'b1;
            else                a[40] = 1'b0;
            sp = 4'($urandom);
            pp = ($urandom % 2) ? sp : 4'($urandom);
            do_frame(a, sp, 1'($urandom), pp, $urandom % 4);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule